// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block is the character engine of an asynchronous serial port. It holds one transmitter and one receiver. They share a baud tick generator that fires once every `baud_div + 1` clocks. Sixteen ticks make one bit time. The transmitter takes an 8-bit character on a start strobe. It drives the line low for one start bit, sends the data bits least significant first, then an optional parity bit, then one or two high stop bits. The idle line level is 1.

The receiver brings the line into the clock domain through a synchronizer. It watches for a falling edge and confirms the start bit at mid-bit, on the eighth tick. It then samples each later bit at its centre and rebuilds the character. For one clock it presents the character together with a parity-error flag and a framing-error flag. The receiver checks only the first stop bit, whatever the stop-length setting. A line that is already low where a second stop bit would sit is taken as the start of the next character.

Three static inputs set the frame format: parity on/off, parity sense and stop length. The transmitter captures them when it accepts a character. The receiver captures the parity settings when it confirms a start bit. Queues, interrupts, modem lines and register access sit outside this block.

Top module: `serial_framer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `txd` is 1, `tx_busy` is 0 and `rx_valid` is 0. A reset in the middle of a frame aborts both engines.
- R2: An accepted character appears on `txd` as a start bit of 0 followed by the 8 data bits, bit 0 first. Each bit lasts 16 baud ticks, which is 16*(baud_div+1) clocks.
- R3: When `par_en`=1, a parity bit follows the data. It makes the count of ones over data plus parity even when `par_odd`=0, and odd when `par_odd`=1. When `par_en`=0, no parity bit is sent.
- R4: `stop_two`=0 appends one stop bit of 1 and `stop_two`=1 appends two. `tx_busy` stays high through the last stop bit and returns low after it. `txd` is 1 whenever `tx_busy` is low.
- R5: `tx_start` is accepted only while `tx_busy` is low. A strobe during a frame has no effect, and no extra frame follows.
- R6: A low pulse on `rxd` that has ended before mid-bit of a start bit is rejected, and no character is reported.
- R7: The receiver reports each character as a `rx_valid` pulse exactly one clock long, with the received byte on `rx_data`.
- R8: When `par_en`=1, `rx_par_err` is 1 with `rx_valid` if the ones over data plus the received parity bit break the rule set by `par_odd`. It is 0 for a well-formed frame.
- R9: `rx_frm_err` is 1 with `rx_valid` when the line is 0 at the centre of the first stop bit. The error flags are never high without `rx_valid`.
- R10: The receiver checks only the first stop bit, even when `stop_two`=1. A start bit that begins right after one stop bit is received as the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | 16 | Clocks per baud tick minus one (16 ticks per bit) |
| par_en | input | 1 | 1 = parity bit sent and checked |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| stop_two | input | 1 | 0 = one stop bit, 1 = two stop bits on transmit |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | 8 | Character to send |
| tx_busy | output | 1 | Transmitter is sending a frame |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | One-clock strobe for a received character |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity mismatch, valid with `rx_valid` |
| rx_frm_err | output | 1 | First stop bit was 0, valid with `rx_valid` |

## Verification
The hardest case to reach is a start bit that arrives where the second stop bit would be. A transmitter that obeys its own stop setting never produces it. To reach it, the bench leaves the transmitter aside. It drives `rxd` itself and sends two frames with only one stop bit between them, while `stop_two` is set. Frames with a low stop bit, a wrong parity bit and a short start glitch are built the same way. The other formats run as loopback vectors, where `txd` feeds `rxd`.

// File: rtl/serial_framer_pkg.sv
package serial_framer_pkg;

   typedef enum logic [2:0] {
      TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
   } tx_state_t;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
   } rx_state_t;

   typedef struct packed {
      logic par_en;
      logic par_odd;
      logic stop_two;
   } frame_cfg_t;

endpackage

// File: rtl/framer_baud.sv
module framer_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= div) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end
endmodule

// File: rtl/framer_tx.sv
module framer_tx
   import serial_framer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  frame_cfg_t        cfg,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   output logic              busy,
   output logic              line
);
   localparam int SUB_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   tx_state_t         state_q;
   logic [SUB_W-1:0]  sub_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              pbit_q;
   frame_cfg_t        cfg_q;
   logic              line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= TX_IDLE;
         sub_q   <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         pbit_q  <= 1'b0;
         cfg_q   <= '0;
         line_q  <= 1'b1;
      end else if (state_q == TX_IDLE) begin
         if (start) begin
            sh_q    <= data;
            pbit_q  <= (^data) ^ cfg.par_odd;
            cfg_q   <= cfg;
            sub_q   <= '0;
            idx_q   <= '0;
            line_q  <= 1'b0;
            state_q <= TX_START;
         end
      end else if (tick) begin
         if (sub_q != SUB_LAST) begin
            sub_q <= sub_q + 1'b1;
         end else begin
            sub_q <= '0;
            unique case (state_q)
               TX_START: begin
                  line_q  <= sh_q[0];
                  state_q <= TX_DATA;
               end
               TX_DATA: begin
                  if (idx_q == IDX_LAST) begin
                     if (cfg_q.par_en) begin
                        line_q  <= pbit_q;
                        state_q <= TX_PAR;
                     end else begin
                        line_q  <= 1'b1;
                        state_q <= TX_STOP1;
                     end
                  end else begin
                     idx_q  <= idx_q + 1'b1;
                     sh_q   <= sh_q >> 1;
                     line_q <= sh_q[1];
                  end
               end
               TX_PAR: begin
                  line_q  <= 1'b1;
                  state_q <= TX_STOP1;
               end
               TX_STOP1: begin
                  line_q  <= 1'b1;
                  state_q <= cfg_q.stop_two ? TX_STOP2 : TX_IDLE;
               end
               TX_STOP2: begin
                  line_q  <= 1'b1;
                  state_q <= TX_IDLE;
               end
               default: state_q <= TX_IDLE;
            endcase
         end
      end
   end

   assign busy = (state_q != TX_IDLE);
   assign line = line_q;
endmodule

// File: rtl/framer_rx.sv
module framer_rx
   import serial_framer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              rxd,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              par_err_o,
   output logic              frm_err_o
);
   localparam int SUB_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
   localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   logic line_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = rxd;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sq;
      always_ff @(posedge clk) begin
         if (rst) sq <= 1'b1;
         else     sq <= rxd;
      end
      assign line_s = sq;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk) begin
         if (rst) sq <= '1;
         else     sq <= {sq[SYNC_STAGES-2:0], rxd};
      end
      assign line_s = sq[SYNC_STAGES-1];
   end

   rx_state_t         state_q;
   logic [SUB_W-1:0]  sub_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              prev_q;
   logic              acc_q;
   logic              perr_q;
   logic              pen_q;
   logic              podd_q;
   logic              centre;

   assign centre = tick && (sub_q == SUB_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= RX_IDLE;
         sub_q     <= '0;
         idx_q     <= '0;
         sh_q      <= '0;
         prev_q    <= 1'b1;
         acc_q     <= 1'b0;
         perr_q    <= 1'b0;
         pen_q     <= 1'b0;
         podd_q    <= 1'b0;
         valid_o   <= 1'b0;
         data_o    <= '0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
      end else begin
         prev_q    <= line_s;
         valid_o   <= 1'b0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
         if (tick && !centre && state_q != RX_IDLE) sub_q <= sub_q + 1'b1;
         unique case (state_q)
            RX_IDLE: begin
               if (prev_q && !line_s) begin
                  sub_q   <= '0;
                  state_q <= RX_START;
               end
            end
            RX_START: begin
               if (tick && sub_q == SUB_MID) begin
                  sub_q <= '0;
                  if (!line_s) begin
                     idx_q   <= '0;
                     acc_q   <= 1'b0;
                     perr_q  <= 1'b0;
                     pen_q   <= par_en;
                     podd_q  <= par_odd;
                     state_q <= RX_DATA;
                  end else begin
                     state_q <= RX_IDLE;
                  end
               end
            end
            RX_DATA: begin
               if (centre) begin
                  sub_q <= '0;
                  sh_q  <= {line_s, sh_q[DATA_W-1:1]};
                  acc_q <= acc_q ^ line_s;
                  if (idx_q == IDX_LAST) state_q <= pen_q ? RX_PAR : RX_STOP;
                  else                   idx_q   <= idx_q + 1'b1;
               end
            end
            RX_PAR: begin
               if (centre) begin
                  sub_q   <= '0;
                  perr_q  <= acc_q ^ line_s ^ podd_q;
                  state_q <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (centre) begin
                  sub_q     <= '0;
                  data_o    <= sh_q;
                  valid_o   <= 1'b1;
                  par_err_o <= perr_q;
                  frm_err_o <= !line_s;
                  state_q   <= RX_IDLE;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/serial_framer.sv
module serial_framer
   import serial_framer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop_two,
   input  logic              tx_start,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              txd,
   input  logic              rxd,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_par_err,
   output logic              rx_frm_err
);
   if (DATA_W < 2) begin : g_bad_width
      $error("serial_framer: DATA_W must be at least 2");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("serial_framer: OVS must be even and at least 4");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("serial_framer: DIV_W must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("serial_framer: SYNC_STAGES must not be negative");
   end

   logic       tick;
   frame_cfg_t cfg;

   assign cfg = '{par_en: par_en, par_odd: par_odd, stop_two: stop_two};

   framer_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst  (rst),
      .div  (baud_div),
      .tick (tick)
   );

   framer_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .cfg   (cfg),
      .start (tx_start),
      .data  (tx_data),
      .busy  (tx_busy),
      .line  (txd)
   );

   framer_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .rxd       (rxd),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .valid_o   (rx_valid),
      .data_o    (rx_data),
      .par_err_o (rx_par_err),
      .frm_err_o (rx_frm_err)
   );
endmodule

// File: rtl/serial_framer_chk.sv
module serial_framer_chk (
   input logic clk,
   input logic rst,
   input logic tx_start,
   input logic tx_busy,
   input logic txd,
   input logic rx_valid,
   input logic rx_par_err,
   input logic rx_frm_err
);
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (txd && !tx_busy && !rx_valid));

   p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_busy) |-> !txd);

   p_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
      !tx_busy |-> txd);

   p_busy_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (tx_busy && tx_start && !txd) |=> tx_busy);

   p_one_clock_r7: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   p_flags_valid_r9: assert property (@(posedge clk) disable iff (rst)
      (rx_par_err || rx_frm_err) |-> rx_valid);
endmodule

bind serial_framer serial_framer_chk i_chk (
   .clk        (clk),
   .rst        (rst),
   .tx_start   (tx_start),
   .tx_busy    (tx_busy),
   .txd        (txd),
   .rx_valid   (rx_valid),
   .rx_par_err (rx_par_err),
   .rx_frm_err (rx_frm_err)
);

// File: tb/test_serial_framer.sv
module test_serial_framer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] baud_div = 16'd0;
   logic        par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0;
   logic        tx_start = 1'b0;
   logic [7:0]  tx_data = 8'h00;
   logic        tx_busy, txd, rx_valid, rx_par_err, rx_frm_err;
   logic [7:0]  rx_data;
   logic        loop_sel = 1'b0;
   logic        drv_line = 1'b1;
   logic        rxd;
   int          n_vec = 0, n_bad = 0;
   bit          done = 0;

   assign rxd = loop_sel ? txd : drv_line;

   always #10 clk = ~clk;

   serial_framer i_serial_framer (
      .clk(clk), .rst(rst), .baud_div(baud_div), .par_en(par_en), .par_odd(par_odd),
      .stop_two(stop_two), .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy),
      .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
   );

   typedef struct packed {
      logic [7:0] d;
      logic       pe;
      logic       po;
      logic       st;
      logic [1:0] div;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{d: 8'h55, pe: 1'b0, po: 1'b0, st: 1'b0, div: 2'd0},
      '{d: 8'hA3, pe: 1'b1, po: 1'b0, st: 1'b0, div: 2'd0},
      '{d: 8'hA3, pe: 1'b1, po: 1'b1, st: 1'b0, div: 2'd0},
      '{d: 8'h00, pe: 1'b1, po: 1'b0, st: 1'b1, div: 2'd0},
      '{d: 8'hFF, pe: 1'b1, po: 1'b1, st: 1'b1, div: 2'd0},
      '{d: 8'h80, pe: 1'b0, po: 1'b0, st: 1'b1, div: 2'd1},
      '{d: 8'h6E, pe: 1'b1, po: 1'b0, st: 1'b0, div: 2'd2},
      '{d: 8'h01, pe: 1'b1, po: 1'b1, st: 1'b1, div: 2'd1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [7:0] d);
      @(negedge clk);
      tx_data  = d;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
   endtask

   // Decode one frame from txd by sampling at bit centres.
   task automatic watch_tx(input logic [7:0] d, input logic pe, input logic po,
                           input logic st, input int bitc);
      int   nb;
      logic [11:0] fr;
      logic busy_last;
      bit   seen;
      nb   = 10 + int'(pe) + int'(st);
      seen = 0;
      fr   = '0;
      for (int w = 0; w < 8 * bitc && !seen; w++) begin
         @(negedge clk);
         if (txd === 1'b0) seen = 1;
      end
      chk("R2 start edge seen", 32'(seen), 32'd1);
      for (int k = 0; k < nb; k++) begin
         repeat ((k == 0) ? bitc / 2 : bitc) @(negedge clk);
         fr[k] = txd;
      end
      busy_last = tx_busy;
      chk("R2 start bit", 32'(fr[0]), 32'd0);
      chk("R2 data bits LSB first", 32'(fr[8:1]), 32'(d));
      if (pe) chk("R3 parity bit", 32'(fr[9]), 32'((^d) ^ po));
      chk("R4 first stop", 32'(fr[9 + int'(pe)]), 32'd1);
      if (st) chk("R4 second stop", 32'(fr[10 + int'(pe)]), 32'd1);
      chk("R4 busy through last stop", 32'(busy_last), 32'd1);
      repeat (bitc / 2 + 2) @(negedge clk);
      chk("R4 busy falls after stop", 32'(tx_busy), 32'd0);
   endtask

   task automatic wait_rx(input int tmo, output bit got, output logic [7:0] d,
                          output logic pe_f, output logic fe_f);
      got = 0; d = '0; pe_f = 1'b0; fe_f = 1'b0;
      for (int w = 0; w < tmo && !got; w++) begin
         @(negedge clk);
         if (rx_valid === 1'b1) begin
            got = 1; d = rx_data; pe_f = rx_par_err; fe_f = rx_frm_err;
            @(negedge clk);
            chk("R7 valid one clock", 32'(rx_valid), 32'd0);
         end
      end
   endtask

   task automatic drive_frame(input logic [7:0] d, input bit with_par, input logic pbit,
                              input logic stopv, input int bitc);
      drv_line = 1'b0;
      repeat (bitc) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         drv_line = d[i];
         repeat (bitc) @(negedge clk);
      end
      if (with_par) begin
         drv_line = pbit;
         repeat (bitc) @(negedge clk);
      end
      drv_line = stopv;
      repeat (bitc) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      bit got;
      logic [7:0] rd;
      logic pf, ff;

      repeat (3) @(negedge clk);
      chk("R1 txd high in reset", 32'(txd), 32'd1);
      chk("R1 busy low in reset", 32'(tx_busy), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 txd after reset", 32'(txd), 32'd1);
      chk("R1 busy after reset", 32'(tx_busy), 32'd0);
      chk("R1 no rx_valid", 32'(rx_valid), 32'd0);

      // Loopback vector walk
      loop_sel = 1'b1;
      foreach (VECS[i]) begin
         int bitc;
         bitc     = 16 * (int'(VECS[i].div) + 1);
         baud_div = 16'(VECS[i].div);
         par_en   = VECS[i].pe;
         par_odd  = VECS[i].po;
         stop_two = VECS[i].st;
         repeat (4) @(negedge clk);
         fork
            pulse_start(VECS[i].d);
            watch_tx(VECS[i].d, VECS[i].pe, VECS[i].po, VECS[i].st, bitc);
            begin
               wait_rx(14 * bitc + 50, got, rd, pf, ff);
               chk("R7 char received", 32'(got), 32'd1);
               chk("R7 rx data", 32'(rd), 32'(VECS[i].d));
               chk("R8 no parity error", 32'(pf), 32'd0);
               chk("R9 no framing error", 32'(ff), 32'd0);
            end
         join
         repeat (bitc) @(negedge clk);
      end

      // R5: strobe while busy is ignored
      baud_div = 16'd0; par_en = 1'b0; par_odd = 1'b0; stop_two = 1'b0;
      repeat (4) @(negedge clk);
      fork
         begin
            pulse_start(8'hC9);
            repeat (40) @(negedge clk);
            pulse_start(8'h36);
         end
         watch_tx(8'hC9, 1'b0, 1'b0, 1'b0, 16);
         begin
            wait_rx(14 * 16 + 50, got, rd, pf, ff);
            chk("R5 first char kept", 32'(rd), 32'hC9);
         end
      join
      begin
         bit stayed;
         stayed = 1;
         for (int w = 0; w < 48; w++) begin
            @(negedge clk);
            if (txd !== 1'b1 || tx_busy !== 1'b0) stayed = 0;
         end
         chk("R5 no second frame", 32'(stayed), 32'd1);
      end

      // Receiver directed tests, bench drives rxd
      loop_sel = 1'b0;
      drv_line = 1'b1;
      repeat (20) @(negedge clk);

      // R6: short glitch rejected
      drv_line = 1'b0;
      repeat (4) @(negedge clk);
      drv_line = 1'b1;
      wait_rx(4 * 16, got, rd, pf, ff);
      chk("R6 glitch not reported", 32'(got), 32'd0);

      // R8: wrong parity bit, even mode, 0x07 needs parity 1
      par_en = 1'b1; par_odd = 1'b0;
      fork
         begin
            drive_frame(8'h07, 1'b1, 1'b0, 1'b1, 16);
            drv_line = 1'b1;
         end
         begin
            wait_rx(13 * 16 + 50, got, rd, pf, ff);
            chk("R8 char with bad parity", 32'(rd), 32'h07);
            chk("R8 parity error raised", 32'(pf), 32'd1);
            chk("R8 framing clean", 32'(ff), 32'd0);
         end
      join
      repeat (32) @(negedge clk);

      // R9: stop bit low
      par_en = 1'b0;
      fork
         begin
            drive_frame(8'hC4, 1'b0, 1'b0, 1'b0, 16);
            repeat (16) @(negedge clk);
            drv_line = 1'b1;
         end
         begin
            wait_rx(12 * 16 + 50, got, rd, pf, ff);
            chk("R9 char with bad stop", 32'(rd), 32'hC4);
            chk("R9 framing error raised", 32'(ff), 32'd1);
            chk("R9 parity clean", 32'(pf), 32'd0);
         end
      join
      repeat (48) @(negedge clk);

      // R10: two stops configured, next start in second stop slot
      stop_two = 1'b1;
      fork
         begin
            drive_frame(8'h5A, 1'b0, 1'b0, 1'b1, 16);
            drive_frame(8'hE1, 1'b0, 1'b0, 1'b1, 16);
            drv_line = 1'b1;
         end
         begin
            wait_rx(12 * 16 + 50, got, rd, pf, ff);
            chk("R10 first char", 32'(rd), 32'h5A);
            chk("R10 first char no frame error", 32'(ff), 32'd0);
            wait_rx(12 * 16 + 50, got, rd, pf, ff);
            chk("R10 second char received", 32'(got), 32'd1);
            chk("R10 second char", 32'(rd), 32'hE1);
            chk("R10 second char no frame error", 32'(ff), 32'd0);
         end
      join
      repeat (32) @(negedge clk);

      // R1: reset in mid-frame
      loop_sel = 1'b1;
      stop_two = 1'b0;
      pulse_start(8'h00);
      repeat (50) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 txd high after mid-frame reset", 32'(txd), 32'd1);
      chk("R1 busy low after mid-frame reset", 32'(tx_busy), 32'd0);
      chk("R1 rx_valid low after mid-frame reset", 32'(rx_valid), 32'd0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule